// File: doc/BRIEF.md
# Programmable Audio Word-Clock Generator

This block derives an audio frame (word) clock from a bit clock that is already present. It runs in the system clock domain. It counts bit-clock periods, which arrive as a one-cycle tick enable. The output level spends a programmable number of periods high and then a programmable number low. Each time a high phase begins, a one-cycle frame-start pulse is raised alongside the level.

Software writes a 16-bit divide word and a 2-bit shaping mode through plain write ports. These writes land in shadow registers, and a separate load strobe copies them into the active set. There are three shaping modes:

- a single-period high pulse followed by a programmable low time;
- a symmetric square wave with one programmable half-period;
- independent high and low lengths, taken from the two bytes of the divide word.

The fourth mode code falls back to the single-pulse shape. After reset the output stays low until the first load.

Top module: `wclk_frame_gen`

## Requirements
- R1: After reset, `wclk` and `frame_start` stay low, whatever the tick input does, until the first load strobe.
- R2: Mode code 0 gives a high phase of exactly 1 tick and a low phase of `div[9:0]` ticks. Bits 15:10 of the divide word have no effect.
- R3: Mode code 1 gives high and low phases of `div[9:0]` ticks each, for a frame of twice that value.
- R4: Mode code 2 gives a high phase of `div[7:0]` ticks and a low phase of `div[15:8]` ticks.
- R5: Mode code 3 produces the same waveform as mode code 0.
- R6: A phase-length field whose active value is zero acts as a length of 1 tick.
- R7: Writes to the divide word or the mode leave the running waveform unchanged until a load strobe is given.
- R8: After a load strobe, the first tick in a later cycle restarts the waveform at the start of a high phase, using the loaded settings, even in the middle of a phase. `frame_start` is high for one system-clock cycle at the start of every high phase and at no other time.
- R9: `wclk` and `frame_start` change only at clock edges where `bclk_tick` is high. `frame_start` is therefore never high in a cycle that follows a non-tick edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_tick | input | 1 | One-cycle enable, high once per bit-clock period |
| div_wr_en | input | 1 | Write strobe for the shadow divide word |
| div_wr_data | input | 16 | Divide word written to the shadow register |
| mode_wr_en | input | 1 | Write strobe for the shadow mode |
| mode_wr_data | input | 2 | Shaping-mode code written to the shadow register |
| load | input | 1 | Copies shadow settings to the active set and requests a restart |
| wclk | output | 1 | Registered word-clock level |
| frame_start | output | 1 | One-cycle pulse at the start of each high phase |

## Verification
A vector table runs each mode at ordinary lengths and at the extremes 1, 255 and 1023. It measures the high and low run lengths in ticks. This separates an off-by-one in either phase counter from a swapped byte field in the split mode. Further vectors set the upper divide bits, zero fields, and mode code 3. Each of these gives the same waveform as a simpler word only if the masking, clamping and fallback are right. Directed cases write new settings without a load and check that the old waveform continues. They also load in the middle of a high phase and in the middle of a low phase, to catch a restart that only happens at a phase boundary. Idle cycles between ticks show any change that is not gated by the tick.

// File: rtl/wcg_pkg.sv
package wcg_pkg;

   typedef enum logic [1:0] {
      SHAPE_PULSE = 2'd0,
      SHAPE_SQUARE = 2'd1,
      SHAPE_SPLIT = 2'd2,
      SHAPE_SPARE = 2'd3
   } shape_e;

   function automatic int unsigned wcg_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/wcg_cfg_regs.sv
module wcg_cfg_regs
   import wcg_pkg::*;
#(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             div_wr_en,
   input  logic [DIV_W-1:0] div_wr_data,
   input  logic             mode_wr_en,
   input  shape_e           mode_wr_data,
   input  logic             load,
   output logic [DIV_W-1:0] act_div,
   output shape_e           act_mode
);

   logic [DIV_W-1:0] shd_div;
   shape_e           shd_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_div  <= '0;
         shd_mode <= SHAPE_PULSE;
      end else begin
         if (div_wr_en)  shd_div  <= div_wr_data;
         if (mode_wr_en) shd_mode <= mode_wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_div  <= '0;
         act_mode <= SHAPE_PULSE;
      end else if (load) begin
         act_div  <= shd_div;
         act_mode <= shd_mode;
      end
   end

   // R7: active settings only move on a load strobe
   a_r7_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ($stable(act_div) && $stable(act_mode)));

endmodule

// File: rtl/wcg_phase_decode.sv
module wcg_phase_decode
   import wcg_pkg::*;
#(
   parameter int unsigned DIV_W   = 16,
   parameter int unsigned WIDE_W  = 10,
   parameter int unsigned SPLIT_W = 8,
   parameter int unsigned LEN_W   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] act_div,
   input  shape_e           act_mode,
   output logic [LEN_W-1:0] high_len,
   output logic [LEN_W-1:0] low_len
);

   localparam int unsigned NUM_FIELDS = 2;
   localparam logic [LEN_W-1:0] ONE_LEN = LEN_W'(1);

   logic [LEN_W-1:0] wide_f;
   logic [LEN_W-1:0] lo_byte_f;
   logic [LEN_W-1:0] hi_byte_f;
   logic [LEN_W-1:0] raw_len [NUM_FIELDS];
   logic [LEN_W-1:0] fin_len [NUM_FIELDS];

   assign wide_f    = LEN_W'(act_div[WIDE_W-1:0]);
   assign lo_byte_f = LEN_W'(act_div[SPLIT_W-1:0]);
   assign hi_byte_f = LEN_W'(act_div[2*SPLIT_W-1:SPLIT_W]);

   always_comb begin
      unique case (act_mode)
         SHAPE_SQUARE: begin
            raw_len[0] = wide_f;
            raw_len[1] = wide_f;
         end
         SHAPE_SPLIT: begin
            raw_len[0] = lo_byte_f;
            raw_len[1] = hi_byte_f;
         end
         default: begin
            raw_len[0] = ONE_LEN;
            raw_len[1] = wide_f;
         end
      endcase
   end

   // index 0 is the high phase, index 1 the low phase
   for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_clamp
      assign fin_len[gi] = (raw_len[gi] == '0) ? ONE_LEN : raw_len[gi];
   end

   assign high_len = fin_len[0];
   assign low_len  = fin_len[1];

   // R6: decoded lengths never reach zero
   a_r6_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      (high_len != '0) && (low_len != '0));

endmodule

// File: rtl/wcg_phase_counter.sv
module wcg_phase_counter #(
   parameter int unsigned LEN_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [LEN_W-1:0] high_len,
   input  logic [LEN_W-1:0] low_len,
   output logic             wclk,
   output logic             frame_start
);

   logic             running;
   logic             restart_pend;
   logic [LEN_W-1:0] remain;
   logic             last_period;

   assign last_period = (remain <= LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running      <= 1'b0;
         restart_pend <= 1'b0;
         remain       <= '0;
         wclk         <= 1'b0;
         frame_start  <= 1'b0;
      end else begin
         frame_start <= 1'b0;
         if (tick && restart_pend) begin
            running      <= 1'b1;
            restart_pend <= 1'b0;
            wclk         <= 1'b1;
            remain       <= high_len;
            frame_start  <= 1'b1;
         end else if (tick && running) begin
            if (last_period) begin
               if (wclk) begin
                  wclk   <= 1'b0;
                  remain <= low_len;
               end else begin
                  wclk        <= 1'b1;
                  remain      <= high_len;
                  frame_start <= 1'b1;
               end
            end else begin
               remain <= remain - LEN_W'(1);
            end
         end
         if (load) restart_pend <= 1'b1;
      end
   end

   // R1: idle generator keeps the output low
   a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (!wclk && !frame_start));

   // R9: no tick, no output change
   a_r9_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(wclk) && !frame_start));

   // R8: frame start only ever accompanies a high level
   a_r8_start_high: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> wclk);

   // R6: a running counter never holds a zero length
   a_r6_remain_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (remain != '0));

endmodule

// File: rtl/wclk_frame_gen.sv
module wclk_frame_gen
   import wcg_pkg::*;
#(
   parameter int unsigned DIV_W   = 16,
   parameter int unsigned WIDE_W  = 10,
   parameter int unsigned SPLIT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_tick,
   input  logic             div_wr_en,
   input  logic [DIV_W-1:0] div_wr_data,
   input  logic             mode_wr_en,
   input  logic [1:0]       mode_wr_data,
   input  logic             load,
   output logic             wclk,
   output logic             frame_start
);

   localparam int unsigned LEN_W = wcg_max(WIDE_W, SPLIT_W);

   if (WIDE_W > DIV_W) begin : g_bad_wide
      $error("WIDE_W must not exceed DIV_W");
   end
   if (2 * SPLIT_W > DIV_W) begin : g_bad_split
      $error("two SPLIT_W fields must fit in DIV_W");
   end
   if (SPLIT_W == 0 || WIDE_W == 0) begin : g_bad_zero
      $error("field widths must be nonzero");
   end

   logic [DIV_W-1:0] act_div;
   shape_e           act_mode;
   logic [LEN_W-1:0] high_len;
   logic [LEN_W-1:0] low_len;

   wcg_cfg_regs #(.DIV_W(DIV_W)) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .div_wr_en    (div_wr_en),
      .div_wr_data  (div_wr_data),
      .mode_wr_en   (mode_wr_en),
      .mode_wr_data (shape_e'(mode_wr_data)),
      .load         (load),
      .act_div      (act_div),
      .act_mode     (act_mode)
   );

   wcg_phase_decode #(
      .DIV_W   (DIV_W),
      .WIDE_W  (WIDE_W),
      .SPLIT_W (SPLIT_W),
      .LEN_W   (LEN_W)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_div  (act_div),
      .act_mode (act_mode),
      .high_len (high_len),
      .low_len  (low_len)
   );

   wcg_phase_counter #(.LEN_W(LEN_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (bclk_tick),
      .load        (load),
      .high_len    (high_len),
      .low_len     (low_len),
      .wclk        (wclk),
      .frame_start (frame_start)
   );

endmodule

// File: tb/sim_wclk_frame_gen.sv
module sim_wclk_frame_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk_tick = 1'b0;
   logic        div_wr_en = 1'b0;
   logic [15:0] div_wr_data = '0;
   logic        mode_wr_en = 1'b0;
   logic [1:0]  mode_wr_data = '0;
   logic        load = 1'b0;
   logic        wclk;
   logic        frame_start;

   int n_checks = 0;
   int n_fail = 0;
   bit stable_bad = 1'b0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   wclk_frame_gen u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .bclk_tick    (bclk_tick),
      .div_wr_en    (div_wr_en),
      .div_wr_data  (div_wr_data),
      .mode_wr_en   (mode_wr_en),
      .mode_wr_data (mode_wr_data),
      .load         (load),
      .wclk         (wclk),
      .frame_start  (frame_start)
   );

   // {mode, divide word, expected high ticks, expected low ticks}
   localparam int NV = 12;
   localparam logic [39:0] VEC [NV] = '{
      {2'd0, 16'h0005, 11'd1,    11'd5},    // R2 ordinary
      {2'd0, 16'h0001, 11'd1,    11'd1},    // R2 minimum
      {2'd0, 16'hFFFF, 11'd1,    11'd1023}, // R2 maximum, upper bits ignored
      {2'd1, 16'h0004, 11'd4,    11'd4},    // R3 ordinary
      {2'd1, 16'hFC01, 11'd1,    11'd1},    // R3 minimum, upper bits ignored
      {2'd1, 16'h03FF, 11'd1023, 11'd1023}, // R3 maximum
      {2'd2, 16'h0305, 11'd5,    11'd3},    // R4 byte order
      {2'd2, 16'hFF01, 11'd1,    11'd255},  // R4 low byte 1, high byte 255
      {2'd2, 16'h01FF, 11'd255,  11'd1},    // R4 low byte 255, high byte 1
      {2'd3, 16'h0007, 11'd1,    11'd7},    // R5 spare code
      {2'd0, 16'h0000, 11'd1,    11'd1},    // R6 zero wide field
      {2'd2, 16'h0000, 11'd1,    11'd1}     // R6 zero split fields
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one tick then two idle cycles; level and pulse sampled after the tick edge
   task automatic tick_step(output bit lvl, output bit fs);
      @(negedge clk) bclk_tick = 1'b1;
      @(negedge clk) bclk_tick = 1'b0;
      lvl = wclk;
      fs = frame_start;
      repeat (2) begin
         @(negedge clk);
         if (wclk !== lvl || frame_start !== 1'b0) stable_bad = 1'b1;
      end
   endtask

   task automatic write_cfg(input logic [1:0] m, input logic [15:0] d);
      @(negedge clk);
      div_wr_en = 1'b1; div_wr_data = d;
      mode_wr_en = 1'b1; mode_wr_data = m;
      @(negedge clk);
      div_wr_en = 1'b0; mode_wr_en = 1'b0;
   endtask

   task automatic pulse_load();
      @(negedge clk) load = 1'b1;
      @(negedge clk) load = 1'b0;
   endtask

   // sync on a frame start, then count the high run and the low run
   task automatic measure(input string req, input int exp_h, input int exp_l);
      bit lvl, fs, found;
      int h, l;
      found = 1'b0;
      for (int k = 0; k < 2100 && !found; k++) begin
         tick_step(lvl, fs);
         if (fs) found = 1'b1;
      end
      chk(found && lvl, {req, " frame start seen"}, int'(found), 1);
      h = 1;
      for (int k = 0; k < 1100; k++) begin
         tick_step(lvl, fs);
         if (lvl) h++;
         else break;
      end
      l = 1;
      for (int k = 0; k < 1100; k++) begin
         tick_step(lvl, fs);
         if (!lvl) l++;
         else break;
      end
      chk(h == exp_h, {req, " high ticks"}, h, exp_h);
      chk(l == exp_l, {req, " low ticks"}, l, exp_l);
      chk(fs == 1'b1, {req, " pulse at next high"}, int'(fs), 1);
   endtask

   initial begin
      bit lvl, fs;
      bit any_hi;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state and idle before the first load
      chk(wclk == 1'b0 && frame_start == 1'b0, "R1 reset state", int'(wclk), 0);
      any_hi = 1'b0;
      for (int k = 0; k < 6; k++) begin
         tick_step(lvl, fs);
         if (lvl || fs) any_hi = 1'b1;
      end
      write_cfg(2'd1, 16'h0003);
      for (int k = 0; k < 4; k++) begin
         tick_step(lvl, fs);
         if (lvl || fs) any_hi = 1'b1;
      end
      chk(!any_hi, "R1 idle until load", int'(any_hi), 0);

      // table walk: R2 R3 R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         write_cfg(VEC[v][39:38], VEC[v][37:22]);
         pulse_load();
         measure($sformatf("R%0s vec%0d", (v < 3) ? "2" : (v < 6) ? "3" :
                 (v < 9) ? "4" : (v < 10) ? "5" : "6", v),
                 int'(VEC[v][21:11]), int'(VEC[v][10:0]));
      end

      // R7: shadow write without load leaves the waveform alone
      write_cfg(2'd1, 16'h0004);
      pulse_load();
      measure("R7 baseline", 4, 4);
      write_cfg(2'd0, 16'h0009);
      measure("R7 no load", 4, 4);
      pulse_load();
      measure("R7 after load", 1, 9);

      // R8: load in the middle of a high phase
      write_cfg(2'd1, 16'h000A);
      pulse_load();
      tick_step(lvl, fs);
      tick_step(lvl, fs);
      tick_step(lvl, fs);
      write_cfg(2'd0, 16'h0002);
      pulse_load();
      tick_step(lvl, fs);
      chk(lvl && fs, "R8 restart mid-high pulse", int'(fs), 1);
      tick_step(lvl, fs);
      chk(!lvl && !fs, "R8 new one-tick high", int'(lvl), 0);

      // R8: load in the middle of a low phase
      tick_step(lvl, fs);
      chk(!lvl, "R8 still low before reload", int'(lvl), 0);
      write_cfg(2'd2, 16'h0203);
      pulse_load();
      tick_step(lvl, fs);
      chk(lvl && fs, "R8 restart mid-low pulse", int'(fs), 1);
      tick_step(lvl, fs);
      tick_step(lvl, fs);
      chk(lvl && !fs, "R8 no pulse inside high", int'(fs), 0);
      tick_step(lvl, fs);
      chk(!lvl, "R8 loaded high length", int'(lvl), 0);

      // R9: idle cycles between ticks never moved the outputs
      chk(!stable_bad, "R9 outputs steady between ticks", int'(stable_bad), 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule